// File: doc/BRIEF.md
# Status Reporting and Service Request Generator

This block keeps the status-reporting state of an instrument's remote-control port. It latches one-cycle event pulses into three event registers: a standard event register, an error event register and an instrument-condition event register. Each register has its own enable mask. An enabled bit in a register sets that register's summary bit in a serial poll status byte, and the byte has its own enable mask. When an enabled summary bit goes from 0 to 1, the block raises a service request flag (bit 6 of the byte) and drives it on the `srq` output.

The host logic reads an event register with a read strobe, and the read clears that register. It loads masks with a write strobe. It resets all status with a clear strobe. It performs a serial poll with a poll strobe, which reads the byte and drops the request flag. Bus handshaking, command parsing and queues are outside this block. Queue overflows and command errors arrive only as event pulses.

Top module: `svc_req_status`

## Requirements
- R1: After reset the standard event register reads 0x80 (power-on flag in bit 7). The error and instrument event registers read 0x00, all four masks are 0, `srq` is 0 and `pollData` is 0x00.
- R2: A 1 on an event pulse input sets the matching register bit at the next clock edge, and the bit stays set until a read or a clear. In the standard register bit 0 is input overflow, bit 2 is output overflow, bit 4 is execution error, bit 5 is illegal command, bit 6 is user activity and bit 7 is power-on. Bits 1 and 3 always read 0.
- R3: `rdData` shows the register chosen by `rdSel` (0 standard, 1 error, 2 instrument, 3 gives 0x00) in the same cycle. With `rdStb` high, that register clears at the clock edge.
- R4: When `wrStb` is high, `wrData` is loaded at the clock edge into the mask chosen by `wrSel`: 0 standard mask, 1 error mask, 2 instrument mask, 3 poll mask.
- R5: In `pollData`, bit 2 is the OR of (error register AND error mask), bit 3 is the same for the instrument register and bit 5 is the same for the standard register. Bits 0, 1, 4 and 7 are always 0.
- R6: When a summary bit that is set in the poll mask goes from 0 to 1, bit 6 of `pollData` and `srq` go to 1 one cycle later. A summary bit that stays set, or that has several enabled event bits behind it, gives only one request.
- R7: An enabled summary bit requests again only after it has returned to 0.
- R8: A summary bit is 0 whenever no event bit is set in both its register and its mask. Bits set only outside the mask do not hold it at 1.
- R9: A cycle with `pollStb` high shows the full byte, with bit 6, on `pollData`. Bit 6 and `srq` are 0 after that edge unless a new enabled rise occurs in the same cycle.
- R10: `clrStb` clears all three event registers (including the power-on flag), the summary bits and `srq`, and keeps all masks.
- R11: When an event pulse and a read of the same register fall in the same cycle, `rdData` returns the old value and the new event is held after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stdPulse | input | 8 | Standard event pulses |
| errPulse | input | 8 | Error event pulses |
| instPulse | input | 8 | Instrument-condition event pulses |
| rdStb | input | 1 | Read strobe: clears the chosen event register |
| rdSel | input | 2 | Event register select for reads |
| rdData | output | 8 | Selected event register value |
| wrStb | input | 1 | Mask write strobe |
| wrSel | input | 2 | Mask select for writes |
| wrData | input | 8 | Mask write data |
| clrStb | input | 1 | Clear-status strobe |
| pollStb | input | 1 | Serial poll strobe |
| pollData | output | 8 | Serial poll status byte |
| srq | output | 1 | Service request level |

## Verification
The assertions check four things on every cycle:
- Bits 1 and 3 of the standard register never set, and the unused bits of the poll byte stay 0.
- Event bits are never lost without a read or a clear.
- The request flag rises only one cycle after an enabled summary rise.
- A poll or a clear always drops the request flag.

Only the directed scenarios can show the rest:
- The exact summary values for each mask setting.
- The single request for a summary that stays set, and the re-arm after a read.
- The same-cycle read and event case.
- That masks survive a clear-status.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;
  localparam int DW = 8;
  localparam int NREG = 3;
  localparam int SELW = 2;
  localparam int REG_STD = 0;
  localparam int REG_ERR = 1;
  localparam int REG_INST = 2;
  localparam int SUM_ERR = 2;
  localparam int SUM_INST = 3;
  localparam int SUM_STD = 5;
  localparam int REQ_BIT = 6;
  localparam logic [DW-1:0] STD_KEEP = 8'hF5;
  localparam logic [DW-1:0] STD_RESET = 8'h80;

  typedef struct packed {
    logic [NREG-1:0] clrEvt;
    logic [NREG-1:0] wrEn;
    logic wrPollEn;
  } ctl_t;

  function automatic int sumPos(input int idx);
    case (idx)
      REG_STD: return SUM_STD;
      REG_ERR: return SUM_ERR;
      default: return SUM_INST;
    endcase
  endfunction
endpackage

// File: rtl/svc_status_dp.sv
module svc_status_dp
  import svc_status_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NREG-1:0][DW-1:0]   evtPulse,
  input  logic [DW-1:0]             wrData,
  input  ctl_t                      ctl,
  output logic [NREG-1:0][DW-1:0]   evtReg,
  output logic [DW-1:0]             pollEn,
  output logic [DW-1:0]             sumByte
);
  logic [NREG-1:0] sumBit;

  for (genvar g = 0; g < NREG; g++) begin : gEvt
    localparam logic [DW-1:0] KEEP = (g == REG_STD) ? STD_KEEP : {DW{1'b1}};
    localparam logic [DW-1:0] RSTV = (g == REG_STD) ? STD_RESET : '0;
    logic [DW-1:0] enReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtReg[g] <= RSTV;
        enReg <= '0;
      end else begin
        if (ctl.clrEvt[g]) evtReg[g] <= evtPulse[g] & KEEP;
        else evtReg[g] <= evtReg[g] | (evtPulse[g] & KEEP);
        if (ctl.wrEn[g]) enReg <= wrData;
      end
    end

    assign sumBit[g] = |(evtReg[g] & enReg);

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.clrEvt[g] |=> ((evtReg[g] & $past(evtReg[g])) == $past(evtReg[g])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) pollEn <= '0;
    else if (ctl.wrPollEn) pollEn <= wrData;
  end

  always_comb begin
    sumByte = '0;
    for (int i = 0; i < NREG; i++) sumByte[sumPos(i)] = sumBit[i];
  end

  // R2
  std_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtReg[REG_STD] & ~STD_KEEP) == '0);
endmodule

// File: rtl/svc_status_ctrl.sv
module svc_status_ctrl
  import svc_status_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdStb,
  input  logic [SELW-1:0] rdSel,
  input  logic            wrStb,
  input  logic [SELW-1:0] wrSel,
  input  logic            clrStb,
  input  logic            pollStb,
  input  logic [DW-1:0]   sumByte,
  input  logic [DW-1:0]   pollEn,
  output ctl_t            ctl,
  output logic            reqFlag
);
  logic [DW-1:0] maskedSum;
  logic [DW-1:0] prevSum;
  logic riseAny;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ctl.clrEvt[i] = clrStb | (rdStb && (rdSel == SELW'(i)));
      ctl.wrEn[i] = wrStb && (wrSel == SELW'(i));
    end
    ctl.wrPollEn = wrStb && (wrSel == SELW'(NREG));
  end

  assign maskedSum = sumByte & pollEn;
  assign riseAny = |(maskedSum & ~prevSum);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSum <= '0;
      reqFlag <= 1'b0;
    end else begin
      prevSum <= maskedSum;
      if (clrStb) reqFlag <= 1'b0;
      else if (riseAny) reqFlag <= 1'b1;
      else if (pollStb) reqFlag <= 1'b0;
    end
  end

  // R6
  req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqFlag) |-> $past(riseAny));
  // R9
  poll_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pollStb && !riseAny) |=> !reqFlag);
  // R10
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> !reqFlag);
endmodule

// File: rtl/svc_req_status.sv
module svc_req_status
  import svc_status_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [DW-1:0]   stdPulse,
  input  logic [DW-1:0]   errPulse,
  input  logic [DW-1:0]   instPulse,
  input  logic            rdStb,
  input  logic [SELW-1:0] rdSel,
  output logic [DW-1:0]   rdData,
  input  logic            wrStb,
  input  logic [SELW-1:0] wrSel,
  input  logic [DW-1:0]   wrData,
  input  logic            clrStb,
  input  logic            pollStb,
  output logic [DW-1:0]   pollData,
  output logic            srq
);
  logic [NREG-1:0][DW-1:0] evtPulse;
  logic [NREG-1:0][DW-1:0] evtReg;
  logic [DW-1:0] pollEn;
  logic [DW-1:0] sumByte;
  logic reqFlag;
  ctl_t ctl;

  assign evtPulse[REG_STD] = stdPulse;
  assign evtPulse[REG_ERR] = errPulse;
  assign evtPulse[REG_INST] = instPulse;

  svc_status_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .rdSel(rdSel), .wrStb(wrStb),
    .wrSel(wrSel), .clrStb(clrStb), .pollStb(pollStb), .sumByte(sumByte),
    .pollEn(pollEn), .ctl(ctl), .reqFlag(reqFlag)
  );

  svc_status_dp uDp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrData(wrData), .ctl(ctl),
    .evtReg(evtReg), .pollEn(pollEn), .sumByte(sumByte)
  );

  always_comb begin
    rdData = '0;
    if (rdSel < SELW'(NREG)) rdData = evtReg[rdSel];
  end

  always_comb begin
    pollData = sumByte;
    pollData[REQ_BIT] = reqFlag;
  end

  assign srq = reqFlag;

  // R5
  poll_unused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pollData & 8'h93) == 8'h00);
endmodule

// File: tb/svc_req_status_test.sv
module svc_req_status_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] stdPulse = '0, errPulse = '0, instPulse = '0, wrData = '0;
  logic rdStb = 1'b0, wrStb = 1'b0, clrStb = 1'b0, pollStb = 1'b0;
  logic [1:0] rdSel = '0, wrSel = '0;
  logic [7:0] rdData, pollData;
  logic srq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  svc_req_status uut (
    .clk(clk), .rstN(rstN), .stdPulse(stdPulse), .errPulse(errPulse),
    .instPulse(instPulse), .rdStb(rdStb), .rdSel(rdSel), .rdData(rdData),
    .wrStb(wrStb), .wrSel(wrSel), .wrData(wrData), .clrStb(clrStb),
    .pollStb(pollStb), .pollData(pollData), .srq(srq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    stdPulse = '0; errPulse = '0; instPulse = '0;
    rdStb = 0; wrStb = 0; clrStb = 0; pollStb = 0;
  endtask

  task automatic writeMask(input logic [1:0] sel, input logic [7:0] val);
    wrStb = 1; wrSel = sel; wrData = val;
    step();
  endtask

  task automatic doPoll();
    pollStb = 1;
    step();
  endtask

  task automatic readReg(input logic [1:0] sel);
    rdStb = 1; rdSel = sel;
    step();
  endtask

  task automatic t_reset();
    rdSel = 0; #1; check("R1 std", rdData, 8'h80);
    rdSel = 1; #1; check("R1 err", rdData, 8'h00);
    rdSel = 2; #1; check("R1 inst", rdData, 8'h00);
    check("R1 poll", pollData, 8'h00);
    check("R1 srq", {7'b0, srq}, 8'h00);
  endtask

  task automatic t_latch();
    readReg(0);
    rdSel = 0; #1; check("R3 read clears", rdData, 8'h00);
    stdPulse = 8'hFF; step();
    check("R2 std layout", rdData, 8'hF5);
    step(); step();
    check("R2 latched", rdData, 8'hF5);
    rdStb = 1; #1; check("R3 read value", rdData, 8'hF5);
    step();
    check("R3 cleared", rdData, 8'h00);
  endtask

  task automatic t_summary();
    writeMask(1, 8'h01);
    errPulse = 8'h02; step();
    check("R5 disabled bit", pollData, 8'h00);
    errPulse = 8'h01; step();
    check("R5 err summary", pollData, 8'h04);
    step();
    check("R6 unmasked no srq", {7'b0, srq}, 8'h00);
    writeMask(3, 8'h04);
    check("R4 srq not yet", {7'b0, srq}, 8'h00);
    step();
    check("R6 srq set", {7'b0, srq}, 8'h01);
    check("R6 poll byte", pollData, 8'h44);
  endtask

  task automatic t_poll();
    pollStb = 1; #1;
    check("R9 poll shows flag", pollData, 8'h44);
    step();
    check("R9 poll cleared", pollData, 8'h04);
    errPulse = 8'h01; step(); step(); step();
    check("R6 single request", {7'b0, srq}, 8'h00);
  endtask

  task automatic t_rearm();
    rdSel = 1; rdStb = 1; #1;
    check("R3 err read", rdData, 8'h03);
    step();
    check("R7 summary dropped", pollData, 8'h00);
    errPulse = 8'h01; step();
    check("R7 no srq yet", {7'b0, srq}, 8'h00);
    step();
    check("R7 rearmed srq", {7'b0, srq}, 8'h01);
    doPoll();
  endtask

  task automatic t_mask();
    writeMask(2, 8'h03);
    writeMask(3, 8'h0C);
    instPulse = 8'h80; step(); step();
    check("R8 disabled inst", pollData, 8'h04);
    instPulse = 8'h03; step();
    check("R5 inst summary", pollData, 8'h0C);
    step();
    check("R6 inst srq", {7'b0, srq}, 8'h01);
    doPoll(); step();
    check("R6 multi bits one request", {7'b0, srq}, 8'h00);
    rdSel = 2; rdStb = 1; #1;
    check("R3 inst read", rdData, 8'h83);
    step();
    check("R8 all enabled cleared", pollData, 8'h04);
    instPulse = 8'h80; step(); step();
    check("R8 only disabled set", pollData, 8'h04);
    readReg(2);
  endtask

  task automatic t_same();
    instPulse = 8'h20; step();
    rdSel = 2; rdStb = 1; instPulse = 8'h10; #1;
    check("R11 old value", rdData, 8'h20);
    step();
    check("R11 new event kept", rdData, 8'h10);
    readReg(2);
  endtask

  task automatic t_clr();
    writeMask(0, 8'h10);
    writeMask(3, 8'h2C);
    stdPulse = 8'h10; step();
    check("R5 std summary", pollData, 8'h24);
    step();
    check("R6 std srq", {7'b0, srq}, 8'h01);
    clrStb = 1; step();
    check("R10 srq cleared", {7'b0, srq}, 8'h00);
    check("R10 poll cleared", pollData, 8'h00);
    rdSel = 0; #1; check("R10 std cleared", rdData, 8'h00);
    stdPulse = 8'h10; step();
    check("R10 mask kept", pollData, 8'h20);
    step();
    check("R10 srq again", {7'b0, srq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    t_reset();
    t_latch();
    t_summary();
    t_poll();
    t_rearm();
    t_mask();
    t_same();
    t_clr();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule